// File: doc/BRIEF.md
# Automatic Sound Mode Selector

This block is the control side of a television sound demodulator. Software picks a standard code. From then on the selector keeps a live choice of the standard variant and of the broadcast sound mode (mono, stereo, bilingual, second audio program, or a digital carrier). It builds that choice from the identification flags that the demodulator reports for the standard now in use, and from the bit-error figure of the digital carrier. The result is a four-way routing description. Each of the four demodulated source channels receives a source select code for its left side and for its right side. The meaning of each channel is fixed, so the output matrices downstream can stay set to stereo for good.

Some standards share one mono carrier. When one of these is selected and no identification is present, the selector steps through the mono-compatible variants. It waits a programmable number of time-base ticks on each variant, and it stops on the variant where stereo or bilingual identification appears. On a digital standard, the selector drops every channel to analog mono when the carrier is lost or the error figure becomes too high. It returns to digital sound only after the error figure has fallen well below the level that forced the drop. A status word summarises the current mode, and every change of that word raises a one-cycle pulse.

Top module: `snd_mode_sel`

## Requirements
- R1: After a synchronous active-low reset, the active standard code is 0x00, every route field is 0, the status word is 0 and the change pulse is low.
- R2: The route port holds four 6-bit slots for channel selects 0, 1, 3 and 4, in that order from bit 0 upward. In each slot, bits [2:0] give the left source and bits [5:3] give the right source. The source codes are: 0 analog primary, 1 analog secondary, 2 analog stereo left, 3 analog stereo right, 4 digital A, 5 digital B. A pulse on the load input copies the selected code to the active standard on the next clock edge. Unknown codes route primary to every side.
- R3: For the dual-carrier analog codes 0x02, 0x03, 0x04, 0x05, 0x07 and 0x30, each case has its own routing. With no identification, every side is primary. With stereo identification, every channel is stereo left/right. With bilingual identification, which takes precedence, the select-0 and select-1 channels are primary/secondary, the select-3 channel is primary on both sides, and the select-4 channel is secondary on both sides.
- R4: While the active code is 0x03 or 0x08 and neither stereo nor bilingual identification is present, the active code alternates between 0x03 and 0x08 after every DWELL ticks.
- R5: The D/K group is searched in the order 0x04, 0x05, 0x07, 0x0B, and then back to 0x04, with DWELL ticks spent on each code.
- R6: While stereo or bilingual identification is present, the active code does not change on ticks, and the dwell count restarts.
- R7: On the digital codes 0x08, 0x09, 0x0A and 0x0B, with no fallback, the select-0 channel is primary on both sides. The other three channels carry digital sound. With bilingual identification they are A/B, A/A and B/B. With stereo identification each is A/B. Otherwise each is A/A.
- R8: On a digital code, fallback starts when the carrier flag is low or the error figure is at or above ERR_HI. In fallback every side is primary. Fallback ends only when the carrier is present and the error figure is at or below ERR_LO. Values between the two thresholds keep the current state.
- R9: Codes 0x20, 0x21 and 0x40 form the multiplex group. Codes 0x21 and 0x40 route every channel as stereo left/right when the pilot flag is set; otherwise every side is primary. Code 0x20 ignores the pilot. Codes 0x20 and 0x21 honour the SAP flag. When SAP is set, the select-0 and select-1 channels become primary/secondary and the select-4 channel becomes secondary/secondary.
- R10: The status bits are: bit 0 stereo, bit 1 bilingual, bit 2 SAP, bit 3 digital sound active, bit 4 fallback, bit 5 search running. Each change of the status word is flagged by a pulse of exactly one clock cycle, in the same cycle as the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_load_i | input | 1 | Load pulse for a newly selected standard |
| sel_std_i | input | 8 | Selected standard code |
| tick_i | input | 1 | Dwell time-base tick |
| id_stereo_i | input | 1 | Stereo identification of the active standard |
| id_biling_i | input | 1 | Bilingual identification of the active standard |
| pilot_i | input | 1 | Multiplex pilot detected |
| sap_i | input | 1 | Second audio program carrier detected |
| dig_carrier_i | input | 1 | Digital carrier present |
| dig_err_i | input | ERR_W | Digital carrier error figure |
| act_std_o | output | 8 | Active standard code |
| route_o | output | 24 | Four channel slots of left/right source selects |
| status_o | output | 6 | Status word |
| stat_chg_o | output | 1 | One-cycle status change pulse |

## Verification
The assertions check four rules on every cycle. The active code stays stable between ticks and while identification is present. The fallback state holds inside the band between the two thresholds. The select-0 channel stays analog whenever digital sound is active. Every change of the status word comes with the pulse. Only the bench scenarios can show the exact route values of each class, the order in which the groups are searched, the dwell length, and the thresholds at which fallback starts and ends. Random flag patterns across codes that do not search widen that coverage.

// File: rtl/snd_sel_pkg.sv
// Shared types and code classification for the sound mode selector.
// Assumes 8-bit standard codes; route pairs are packed {right,left}.
package snd_sel_pkg;

    typedef enum logic [2:0] {
        SRC_PRI = 3'd0,
        SRC_SEC = 3'd1,
        SRC_STL = 3'd2,
        SRC_STR = 3'd3,
        SRC_DA  = 3'd4,
        SRC_DB  = 3'd5
    } src_e;

    typedef enum logic [1:0] {
        CLS_NONE,
        CLS_DUALFM,
        CLS_DIG,
        CLS_MPX
    } cls_e;

    localparam int NUM_CH  = 4;
    localparam int PAIR_W  = 6;
    localparam int ROUTE_W = NUM_CH * PAIR_W;
    localparam int ST_W    = 6;

    localparam int ST_STEREO = 0;
    localparam int ST_BILING = 1;
    localparam int ST_SAP    = 2;
    localparam int ST_DIG    = 3;
    localparam int ST_FB     = 4;
    localparam int ST_SRCH   = 5;

    function automatic logic [PAIR_W-1:0] pair(src_e l, src_e r);
        return {r, l};
    endfunction

    function automatic cls_e std_class(logic [7:0] c);
        case (c)
            8'h02, 8'h03, 8'h04, 8'h05, 8'h07, 8'h30: return CLS_DUALFM;
            8'h08, 8'h09, 8'h0A, 8'h0B:               return CLS_DIG;
            8'h20, 8'h21, 8'h40:                      return CLS_MPX;
            default:                                  return CLS_NONE;
        endcase
    endfunction

    function automatic logic in_group(logic [7:0] c);
        case (c)
            8'h03, 8'h08, 8'h04, 8'h05, 8'h07, 8'h0B: return 1'b1;
            default:                                  return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] next_std(logic [7:0] c);
        case (c)
            8'h03:   return 8'h08;
            8'h08:   return 8'h03;
            8'h04:   return 8'h05;
            8'h05:   return 8'h07;
            8'h07:   return 8'h0B;
            8'h0B:   return 8'h04;
            default: return c;
        endcase
    endfunction

endpackage

// File: rtl/snd_std_search.sv
// Holds the active standard code and runs the dwell-timed search across
// mono-compatible variants. Assumes tick_i is a single-cycle time base.
module snd_std_search
    import snd_sel_pkg::*;
#(
    parameter int DWELL = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_load_i,
    input  logic [7:0] sel_std_i,
    input  logic       tick_i,
    input  logic       ident_i,
    output logic [7:0] act_std_o,
    output logic       searching_o
);
    localparam int CNT_W = (DWELL > 2) ? $clog2(DWELL) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DWELL - 1);

    logic [7:0]       act_std_q;
    logic [CNT_W-1:0] dwell_q;

    assign searching_o = in_group(act_std_q) && !ident_i;
    assign act_std_o   = act_std_q;

    // Load a new code, restart the dwell on identification, step on dwell expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_std_q <= 8'h00;
            dwell_q   <= '0;
        end else if (sel_load_i) begin
            act_std_q <= sel_std_i;
            dwell_q   <= '0;
        end else if (!searching_o) begin
            dwell_q   <= '0;
        end else if (tick_i) begin
            if (dwell_q == CNT_LAST) begin
                act_std_q <= next_std(act_std_q);
                dwell_q   <= '0;
            end else begin
                dwell_q   <= dwell_q + 1'b1;
            end
        end
    end

    // R6
    hold_on_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_load_i && ident_i) |=> $stable(act_std_q));

    // R4
    step_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_load_i && !tick_i) |=> $stable(act_std_q));

endmodule

// File: rtl/snd_dig_fallback.sv
// Hysteretic digital-to-analog fallback: enters at or above ERR_HI or on
// carrier loss, leaves at or below ERR_LO with carrier. Assumes ERR_LO < ERR_HI.
module snd_dig_fallback #(
    parameter int ERR_W  = 8,
    parameter int ERR_HI = 96,
    parameter int ERR_LO = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_load_i,
    input  logic             dig_std_i,
    input  logic             carrier_i,
    input  logic [ERR_W-1:0] err_i,
    output logic             fb_o
);
    localparam logic [ERR_W-1:0] HI = ERR_W'(ERR_HI);
    localparam logic [ERR_W-1:0] LO = ERR_W'(ERR_LO);

    logic fb_q;
    assign fb_o = fb_q;

    // Track fallback state with separate enter and leave thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n || sel_load_i || !dig_std_i) begin
            fb_q <= 1'b0;
        end else if (!fb_q) begin
            if (!carrier_i || err_i >= HI) fb_q <= 1'b1;
        end else begin
            if (carrier_i && err_i <= LO) fb_q <= 1'b0;
        end
    end

    // R8
    fb_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_load_i && dig_std_i && fb_q && carrier_i && err_i > LO) |=> fb_q);

    // R8
    fb_stay_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_load_i && dig_std_i && !fb_q && carrier_i && err_i < HI) |=> !fb_q);

endmodule

// File: rtl/snd_route_map.sv
// Combinational map from active standard, fallback state and identification
// flags to the four channel route slots and the status word.
module snd_route_map
    import snd_sel_pkg::*;
(
    input  logic [7:0]         act_std_i,
    input  logic               fb_i,
    input  logic               searching_i,
    input  logic               id_stereo_i,
    input  logic               id_biling_i,
    input  logic               pilot_i,
    input  logic               sap_i,
    output logic [ROUTE_W-1:0] route_o,
    output logic [ST_W-1:0]    status_o
);
    logic [PAIR_W-1:0] ch [NUM_CH];
    logic [PAIR_W-1:0] base;
    logic              mpx_st;
    logic              mpx_sap;

    // Work out the per-channel source pairs and status for the current class.
    always_comb begin
        for (int k = 0; k < NUM_CH; k++) ch[k] = pair(SRC_PRI, SRC_PRI);
        status_o = '0;
        status_o[ST_SRCH] = searching_i;
        mpx_st  = pilot_i && (act_std_i != 8'h20);
        mpx_sap = sap_i && (act_std_i != 8'h40);
        base    = mpx_st ? pair(SRC_STL, SRC_STR) : pair(SRC_PRI, SRC_PRI);
        case (std_class(act_std_i))
            CLS_DUALFM: begin
                if (id_biling_i) begin
                    ch[0] = pair(SRC_PRI, SRC_SEC);
                    ch[1] = pair(SRC_PRI, SRC_SEC);
                    ch[3] = pair(SRC_SEC, SRC_SEC);
                    status_o[ST_BILING] = 1'b1;
                end else if (id_stereo_i) begin
                    for (int k = 0; k < NUM_CH; k++) ch[k] = pair(SRC_STL, SRC_STR);
                    status_o[ST_STEREO] = 1'b1;
                end
            end
            CLS_DIG: begin
                if (fb_i) begin
                    status_o[ST_FB] = 1'b1;
                end else begin
                    status_o[ST_DIG] = 1'b1;
                    if (id_biling_i) begin
                        ch[1] = pair(SRC_DA, SRC_DB);
                        ch[2] = pair(SRC_DA, SRC_DA);
                        ch[3] = pair(SRC_DB, SRC_DB);
                        status_o[ST_BILING] = 1'b1;
                    end else if (id_stereo_i) begin
                        for (int k = 1; k < NUM_CH; k++) ch[k] = pair(SRC_DA, SRC_DB);
                        status_o[ST_STEREO] = 1'b1;
                    end else begin
                        for (int k = 1; k < NUM_CH; k++) ch[k] = pair(SRC_DA, SRC_DA);
                    end
                end
            end
            CLS_MPX: begin
                for (int k = 0; k < NUM_CH; k++) ch[k] = base;
                status_o[ST_STEREO] = mpx_st;
                if (mpx_sap) begin
                    ch[0] = pair(SRC_PRI, SRC_SEC);
                    ch[1] = pair(SRC_PRI, SRC_SEC);
                    ch[3] = pair(SRC_SEC, SRC_SEC);
                    status_o[ST_SAP] = 1'b1;
                end
            end
            default: ;
        endcase
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_pack
        assign route_o[g*PAIR_W +: PAIR_W] = ch[g];
    end

endmodule

// File: rtl/snd_mode_sel.sv
// Top of the automatic sound mode selector: search, fallback and routing,
// with registered route, status and a one-cycle status change pulse.
// Assumes all inputs are synchronous to clk.
module snd_mode_sel
    import snd_sel_pkg::*;
#(
    parameter int DWELL  = 64,
    parameter int ERR_W  = 8,
    parameter int ERR_HI = 96,
    parameter int ERR_LO = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_load_i,
    input  logic [7:0]       sel_std_i,
    input  logic             tick_i,
    input  logic             id_stereo_i,
    input  logic             id_biling_i,
    input  logic             pilot_i,
    input  logic             sap_i,
    input  logic             dig_carrier_i,
    input  logic [ERR_W-1:0] dig_err_i,
    output logic [7:0]       act_std_o,
    output logic [23:0]      route_o,
    output logic [5:0]       status_o,
    output logic             stat_chg_o
);
    logic [7:0]         act_std;
    logic               searching;
    logic               fb;
    logic [ROUTE_W-1:0] route_d, route_q;
    logic [ST_W-1:0]    status_d, status_q;
    logic               chg_q;

    snd_std_search #(.DWELL(DWELL)) u_search (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_load_i  (sel_load_i),
        .sel_std_i   (sel_std_i),
        .tick_i      (tick_i),
        .ident_i     (id_stereo_i || id_biling_i),
        .act_std_o   (act_std),
        .searching_o (searching)
    );

    snd_dig_fallback #(.ERR_W(ERR_W), .ERR_HI(ERR_HI), .ERR_LO(ERR_LO)) u_fb (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_load_i (sel_load_i),
        .dig_std_i  (std_class(act_std) == CLS_DIG),
        .carrier_i  (dig_carrier_i),
        .err_i      (dig_err_i),
        .fb_o       (fb)
    );

    snd_route_map u_map (
        .act_std_i   (act_std),
        .fb_i        (fb),
        .searching_i (searching),
        .id_stereo_i (id_stereo_i),
        .id_biling_i (id_biling_i),
        .pilot_i     (pilot_i),
        .sap_i       (sap_i),
        .route_o     (route_d),
        .status_o    (status_d)
    );

    // Register the route and status, flagging each status change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q  <= '0;
            status_q <= '0;
            chg_q    <= 1'b0;
        end else begin
            route_q  <= route_d;
            status_q <= status_d;
            chg_q    <= (status_d != status_q);
        end
    end

    assign act_std_o  = act_std;
    assign route_o    = route_q;
    assign status_o   = status_q;
    assign stat_chg_o = chg_q;

    // R10
    stat_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q != $past(status_q)) |-> stat_chg_o);

    // R7
    dig_ch0_analog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[ST_DIG] |-> (route_q[PAIR_W-1:0] == '0));

endmodule

// File: tb/snd_mode_sel_test.sv
module snd_mode_sel_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_load_i = 1'b0;
    logic [7:0]  sel_std_i = 8'h00;
    logic        tick_i = 1'b0;
    logic        id_stereo_i = 1'b0;
    logic        id_biling_i = 1'b0;
    logic        pilot_i = 1'b0;
    logic        sap_i = 1'b0;
    logic        dig_carrier_i = 1'b1;
    logic [7:0]  dig_err_i = 8'd0;
    logic [7:0]  act_std_o;
    logic [23:0] route_o;
    logic [5:0]  status_o;
    logic        stat_chg_o;

    int total = 0;
    int bad = 0;
    int chg_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    snd_mode_sel #(.DWELL(DW)) uut (
        .clk(clk), .rst_n(rst_n), .sel_load_i(sel_load_i), .sel_std_i(sel_std_i),
        .tick_i(tick_i), .id_stereo_i(id_stereo_i), .id_biling_i(id_biling_i),
        .pilot_i(pilot_i), .sap_i(sap_i), .dig_carrier_i(dig_carrier_i),
        .dig_err_i(dig_err_i), .act_std_o(act_std_o), .route_o(route_o),
        .status_o(status_o), .stat_chg_o(stat_chg_o)
    );

    always @(negedge clk) if (rst_n && stat_chg_o) chg_cnt++;

    // pair codes {right,left}
    localparam logic [5:0] PP = 6'o00, PS = 6'o10, SS = 6'o11, ST = 6'o32,
                           AB = 6'o54, AA = 6'o44, BB = 6'o55;

    function automatic logic [23:0] exp_route(input logic [7:0] c, input logic fb,
        input logic st, input logic bi, input logic pl, input logic sp);
        logic [5:0] b;
        case (c)
            8'h02, 8'h03, 8'h04, 8'h05, 8'h07, 8'h30:
                if (bi) return {SS, PP, PS, PS};
                else if (st) return {ST, ST, ST, ST};
                else return 24'd0;
            8'h08, 8'h09, 8'h0A, 8'h0B:
                if (fb) return 24'd0;
                else if (bi) return {BB, AA, AB, PP};
                else if (st) return {AB, AB, AB, PP};
                else return {AA, AA, AA, PP};
            8'h20, 8'h21, 8'h40: begin
                b = (pl && c != 8'h20) ? ST : PP;
                if (sp && c != 8'h40) return {SS, b, PS, PS};
                return {b, b, b, b};
            end
            default: return 24'd0;
        endcase
    endfunction

    function automatic logic [5:0] exp_status(input logic [7:0] c, input logic fb,
        input logic st, input logic bi, input logic pl, input logic sp);
        logic [5:0] s;
        s = '0;
        case (c)
            8'h02, 8'h03, 8'h04, 8'h05, 8'h07, 8'h30: begin
                s[1] = bi; s[0] = st && !bi;
            end
            8'h08, 8'h09, 8'h0A, 8'h0B:
                if (fb) s[4] = 1'b1;
                else begin s[3] = 1'b1; s[1] = bi; s[0] = st && !bi; end
            8'h20, 8'h21, 8'h40: begin
                s[0] = pl && c != 8'h20; s[2] = sp && c != 8'h40;
            end
            default: ;
        endcase
        if ((c == 8'h03 || c == 8'h08 || c == 8'h04 || c == 8'h05 || c == 8'h07 || c == 8'h0B)
            && !st && !bi) s[5] = 1'b1;
        return s;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load(input logic [7:0] c);
        sel_std_i = c; sel_load_i = 1'b1;
        step(1);
        sel_load_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1; step(1);
            tick_i = 1'b0; step(1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        logic [7:0] codes [7];
        int c0;
        codes = '{8'h02, 8'h30, 8'h20, 8'h21, 8'h40, 8'h09, 8'h0A};
        seed = 11;
        void'($urandom(seed));
        step(3);
        // R1 reset state
        check("R1 std", act_std_o, 8'h00);
        check("R1 route", route_o, 0);
        check("R1 status", status_o, 0);
        check("R1 chg", stat_chg_o, 0);
        rst_n = 1'b1;
        step(2);

        // R2 unknown code, load behaviour
        load(8'h55);
        check("R2 load", act_std_o, 8'h55);
        step(2);
        check("R2 unknown route", route_o, 0);

        // R3 dual carrier analog
        load(8'h02); step(2);
        check("R3 mono", route_o, 0);
        id_stereo_i = 1; step(3);
        check("R3 stereo", route_o, {ST, ST, ST, ST});
        id_biling_i = 1; step(3);
        check("R3 biling", route_o, {SS, PP, PS, PS});
        check("R10 status biling", status_o, 6'b000010);
        id_stereo_i = 0; id_biling_i = 0; step(3);

        // R10 change pulse once per change
        c0 = chg_cnt;
        id_stereo_i = 1; step(4);
        check("R10 one pulse", chg_cnt - c0, 1);
        id_stereo_i = 0; step(4);
        check("R10 second pulse", chg_cnt - c0, 2);

        // R4 B/G alternation
        load(8'h03); step(2);
        check("R4 searching", status_o[5], 1);
        ticks(DW - 1);
        check("R4 before dwell", act_std_o, 8'h03);
        ticks(1);
        check("R4 to 08", act_std_o, 8'h08);
        ticks(DW);
        check("R4 back to 03", act_std_o, 8'h03);

        // R6 hold on identification
        id_biling_i = 1; step(1);
        ticks(3 * DW);
        check("R6 hold", act_std_o, 8'h03);
        step(1);
        check("R6 search off", status_o[5], 0);
        id_biling_i = 0; step(1);

        // R5 D/K order
        load(8'h04);
        ticks(DW); check("R5 05", act_std_o, 8'h05);
        ticks(DW); check("R5 07", act_std_o, 8'h07);
        ticks(DW); check("R5 0B", act_std_o, 8'h0B);
        ticks(DW); check("R5 wrap 04", act_std_o, 8'h04);

        // R7 digital routing, R8 hysteresis
        load(8'h09); id_stereo_i = 1; dig_err_i = 8'd0; step(3);
        check("R7 digital stereo", route_o, {AB, AB, AB, PP});
        dig_err_i = 8'd60; step(3);
        check("R8 mid keeps digital", status_o[3], 1);
        dig_err_i = 8'd95; step(3);
        check("R8 below hi keeps digital", status_o[3], 1);
        dig_err_i = 8'd96; step(3);
        check("R8 enter fallback", route_o, 0);
        check("R8 fb status", status_o, 6'b010000);
        dig_err_i = 8'd33; step(3);
        check("R8 above lo stays fb", status_o[4], 1);
        dig_err_i = 8'd32; step(3);
        check("R8 leave fallback", route_o, {AB, AB, AB, PP});
        dig_carrier_i = 0; step(3);
        check("R8 carrier loss", status_o[4], 1);
        dig_carrier_i = 1; dig_err_i = 0; step(3);
        id_stereo_i = 0; id_biling_i = 1; step(3);
        check("R7 digital biling", route_o, {BB, AA, AB, PP});
        id_biling_i = 0; step(3);
        check("R7 digital mono", route_o, {AA, AA, AA, PP});

        // R9 multiplex
        load(8'h21); pilot_i = 1; sap_i = 1; step(3);
        check("R9 stereo sap", route_o, {SS, ST, PS, PS});
        load(8'h20); step(3);
        check("R9 20 ignores pilot", route_o, {SS, PP, PS, PS});
        load(8'h40); step(3);
        check("R9 40 ignores sap", route_o, {ST, ST, ST, ST});
        pilot_i = 0; sap_i = 0;

        // random patterns on codes that do not search
        for (int i = 0; i < 60; i++) begin
            logic [7:0] c;
            logic st, bi, pl, sp;
            c  = codes[$urandom_range(6)];
            st = 1'($urandom); bi = 1'($urandom);
            pl = 1'($urandom); sp = 1'($urandom);
            load(c);
            id_stereo_i = st; id_biling_i = bi; pilot_i = pl; sap_i = sp;
            step(3);
            check("R3/R7/R9 random route", route_o, exp_route(c, 1'b0, st, bi, pl, sp));
            check("R10 random status", status_o, exp_status(c, 1'b0, st, bi, pl, sp));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule